// File: doc/BRIEF.md
# Single-Wire Pulse-Width Step Decoder

This block turns one combined enable/control line into a 6-bit level code for a voltage-programming DAC. While the line is held high the block is enabled. Each low pulse is timed in whole microseconds, and its width decides the action when the line returns high. A short low pulse raises the code by one step. A medium low pulse lowers it by one step. A low level that lasts long enough shuts the block down at once, without waiting for the line to go high again. A higher code gives a lower regulated output voltage, and code 0 gives the highest.

The line first passes through a two-flop synchroniser. A prescaler divides the system clock down to microsecond ticks. It restarts on every falling edge, so a low pulse is measured to the whole microsecond. A saturating counter holds the low time. Each time the block is enabled from shutdown, it reloads the code to mid-scale and issues a one-cycle softstart request. A one-cycle `stepDone` strobe marks every code change made by a step pulse. The code is updated on the third rising clock edge after the pin returns high.

Top module: `pulse_step_decoder`

## Requirements
- R1: After reset, `enable` is 0, `dacCode` is 32 (mid-scale of 0..63), and `softStart` and `stepDone` are 0.
- R2: A return high of the pin while shut down sets `enable` to 1, pulses `softStart` for exactly one cycle, and loads `dacCode` with 32, whatever value it held before.
- R3: While enabled, a low pulse measured as 1 to 60 whole microseconds, followed by a return high, increases `dacCode` by one.
- R4: While enabled, a low pulse measured as 140 to 240 whole microseconds, followed by a return high, decreases `dacCode` by one.
- R5: A low level lasting 560 microseconds or more clears `enable` while the pin is still low, and `dacCode` then keeps its value until the next enable.
- R6: A low pulse measured as 0, 61 to 139, or 241 to 559 whole microseconds leaves `dacCode` unchanged, raises no `stepDone`, and keeps `enable` at 1.
- R7: `dacCode` saturates: a raise pulse at 63 and a lower pulse at 0 change nothing and raise no `stepDone`.
- R8: `stepDone` is high for exactly one cycle for each step-pulse code change, and never otherwise.
- R9: A high gap of 1 microsecond between consecutive step pulses is enough for every pulse to take effect.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| ctrlPin | input | 1 | Combined enable/step control line, asynchronous |
| dacCode | output | CODE_W (6) | DAC level code, 0 = highest output voltage |
| enable | output | 1 | Block enabled |
| softStart | output | 1 | One-cycle request to begin the softstart sequence |
| stepDone | output | 1 | One-cycle strobe when a step pulse changes the code |

## Verification
The hardest states to reach are the two code rails, because the code always re-centres on enable. To reach them, the stimulus drives 31 back-to-back raise pulses separated by the minimum 1 µs gap, and after a shutdown and re-enable it drives 32 lower pulses. It then applies one more pulse at each rail. The window edges at 1, 60, 61, 139, 140, 240, 241 and 559 µs come from a vector table that holds the pin low for exact multiples of the microsecond period. The bench shortens that period through a parameter to keep the runs short.

// File: rtl/psd_pkg.sv
package psd_pkg;

  // Strobes issued by the control path toward the code register
  typedef struct packed {
    logic load;   // re-centre on enable
    logic inc;    // raise code one step
    logic dec;    // lower code one step
  } step_cmd_t;

endpackage

// File: rtl/psd_ctrl.sv
module psd_ctrl
  import psd_pkg::*;
#(
  parameter int CLK_PER_US  = 50,
  parameter int SYNC_STAGES = 2,
  parameter int UP_MIN_US   = 1,
  parameter int UP_MAX_US   = 60,
  parameter int DN_MIN_US   = 140,
  parameter int DN_MAX_US   = 240,
  parameter int OFF_US      = 560
) (
  input  logic      clk,
  input  logic      rst,
  input  logic      ctrlPin,
  output step_cmd_t cmd,
  output logic      enable,
  output logic      softStart
);

  localparam int PRE_W = (CLK_PER_US > 1) ? $clog2(CLK_PER_US) : 1;
  localparam int LOW_W = $clog2(OFF_US + 1);
  localparam logic [PRE_W-1:0] PRE_LAST = PRE_W'(CLK_PER_US - 1);
  localparam logic [LOW_W-1:0] LOW_SAT  = LOW_W'(OFF_US);

  logic [SYNC_STAGES-1:0] syncChain;
  logic                   syncIn;
  logic                   prevIn;
  logic [PRE_W-1:0]       preCnt;
  logic [LOW_W-1:0]       lowUs;
  logic                   riseEvt;
  logic                   inUp;
  logic                   inDn;
  logic                   offHit;

  // Synchroniser chain for the asynchronous pin
  generate
    if (SYNC_STAGES > 1) begin : g_chain
      always_ff @(posedge clk) begin
        if (rst) syncChain <= '0;
        else     syncChain <= {syncChain[SYNC_STAGES-2:0], ctrlPin};
      end
    end else begin : g_single
      always_ff @(posedge clk) begin
        if (rst) syncChain <= '0;
        else     syncChain <= ctrlPin;
      end
    end
  endgenerate

  assign syncIn = syncChain[SYNC_STAGES-1];

  always_ff @(posedge clk) begin
    if (rst) prevIn <= 1'b0;
    else     prevIn <= syncIn;
  end

  assign riseEvt = syncIn & ~prevIn;

  // Low-time measurement: prescaler restarts at each falling edge,
  // microsecond counter saturates at the shutdown threshold
  always_ff @(posedge clk) begin
    if (rst || syncIn) begin
      preCnt <= '0;
      lowUs  <= '0;
    end else if (preCnt == PRE_LAST) begin
      preCnt <= '0;
      if (lowUs != LOW_SAT) lowUs <= lowUs + 1'b1;
    end else begin
      preCnt <= preCnt + 1'b1;
    end
  end

  assign inUp = (lowUs >= LOW_W'(UP_MIN_US)) && (lowUs <= LOW_W'(UP_MAX_US));
  assign inDn = (lowUs >= LOW_W'(DN_MIN_US)) && (lowUs <= LOW_W'(DN_MAX_US));
  assign offHit = enable && !syncIn && (lowUs == LOW_SAT);

  always_comb begin
    cmd      = '0;
    cmd.load = riseEvt && !enable;
    cmd.inc  = riseEvt && enable && inUp;
    cmd.dec  = riseEvt && enable && inDn;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      enable    <= 1'b0;
      softStart <= 1'b0;
    end else begin
      softStart <= cmd.load;
      if (cmd.load)    enable <= 1'b1;
      else if (offHit) enable <= 1'b0;
    end
  end

endmodule

// File: rtl/psd_datapath.sv
module psd_datapath
  import psd_pkg::*;
#(
  parameter int CODE_W = 6
) (
  input  logic              clk,
  input  logic              rst,
  input  step_cmd_t         cmd,
  output logic [CODE_W-1:0] code,
  output logic              stepDone
);

  localparam logic [CODE_W-1:0] CODE_TOP = {CODE_W{1'b1}};
  localparam logic [CODE_W-1:0] CODE_MID = CODE_W'(1) << (CODE_W - 1);

  logic atTop;
  logic atBot;

  assign atTop = (code == CODE_TOP);
  assign atBot = (code == '0);

  always_ff @(posedge clk) begin
    if (rst) begin
      code     <= CODE_MID;
      stepDone <= 1'b0;
    end else begin
      stepDone <= 1'b0;
      if (cmd.load) begin
        code <= CODE_MID;
      end else if (cmd.inc && !atTop) begin
        code     <= code + 1'b1;
        stepDone <= 1'b1;
      end else if (cmd.dec && !atBot) begin
        code     <= code - 1'b1;
        stepDone <= 1'b1;
      end
    end
  end

endmodule

// File: rtl/pulse_step_decoder.sv
module pulse_step_decoder
  import psd_pkg::*;
#(
  parameter int CODE_W     = 6,
  parameter int CLK_PER_US = 50,
  parameter int UP_MIN_US  = 1,
  parameter int UP_MAX_US  = 60,
  parameter int DN_MIN_US  = 140,
  parameter int DN_MAX_US  = 240,
  parameter int OFF_US     = 560
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              ctrlPin,
  output logic [CODE_W-1:0] dacCode,
  output logic              enable,
  output logic              softStart,
  output logic              stepDone
);

  step_cmd_t cmd;

  psd_ctrl #(
    .CLK_PER_US (CLK_PER_US),
    .SYNC_STAGES(2),
    .UP_MIN_US  (UP_MIN_US),
    .UP_MAX_US  (UP_MAX_US),
    .DN_MIN_US  (DN_MIN_US),
    .DN_MAX_US  (DN_MAX_US),
    .OFF_US     (OFF_US)
  ) u_ctrl (
    .clk      (clk),
    .rst      (rst),
    .ctrlPin  (ctrlPin),
    .cmd      (cmd),
    .enable   (enable),
    .softStart(softStart)
  );

  psd_datapath #(
    .CODE_W(CODE_W)
  ) u_dp (
    .clk     (clk),
    .rst     (rst),
    .cmd     (cmd),
    .code    (dacCode),
    .stepDone(stepDone)
  );

endmodule

// File: rtl/psd_checker.sv
module psd_checker #(
  parameter int CODE_W = 6
) (
  input logic              clk,
  input logic              rst,
  input logic [CODE_W-1:0] dacCode,
  input logic              enable,
  input logic              softStart,
  input logic              stepDone
);

  localparam logic [CODE_W-1:0] TOP = {CODE_W{1'b1}};
  localparam logic [CODE_W-1:0] MID = CODE_W'(1) << (CODE_W - 1);

  // R2: enabling re-centres the code
  assert_recentre_R2: assert property (@(posedge clk) disable iff (rst)
    $rose(enable) |-> (dacCode == MID));

  // R2: softstart request accompanies enable and lasts one cycle
  assert_softstart_on_enable_R2: assert property (@(posedge clk) disable iff (rst)
    $rose(enable) |-> softStart);
  assert_softstart_single_R2: assert property (@(posedge clk) disable iff (rst)
    softStart |=> !softStart);

  // R3 / R4: while enabled the code moves by at most one step
  assert_single_step_R3: assert property (@(posedge clk) disable iff (rst)
    (enable && $past(enable) && (dacCode != $past(dacCode))) |->
      ((dacCode == $past(dacCode) + CODE_W'(1)) || (dacCode == $past(dacCode) - CODE_W'(1))));

  // R5: code frozen during shutdown
  assert_frozen_off_R5: assert property (@(posedge clk) disable iff (rst)
    (!enable && !$past(enable)) |-> $stable(dacCode));

  // R7: no wrap at either rail
  assert_no_wrap_top_R7: assert property (@(posedge clk) disable iff (rst)
    ($past(dacCode) == TOP && $past(enable) && enable) |-> (dacCode != '0));
  assert_no_wrap_bot_R7: assert property (@(posedge clk) disable iff (rst)
    ($past(dacCode) == '0 && $past(enable) && enable) |-> (dacCode != TOP));

  // R8: strobe marks a real code change while enabled, one cycle wide
  assert_strobe_change_R8: assert property (@(posedge clk) disable iff (rst)
    stepDone |-> (enable && (dacCode != $past(dacCode))));
  assert_strobe_single_R8: assert property (@(posedge clk) disable iff (rst)
    stepDone |=> !stepDone);

endmodule

bind pulse_step_decoder psd_checker #(.CODE_W(CODE_W)) u_psd_checker (
  .clk      (clk),
  .rst      (rst),
  .dacCode  (dacCode),
  .enable   (enable),
  .softStart(softStart),
  .stepDone (stepDone)
);

// File: tb/pulse_step_decoder_bench.sv
module pulse_step_decoder_bench;

  localparam int CPU = 4;  // clock cycles per microsecond in this bench

  typedef struct packed {
    int cyc;
    int delta;
  } vec_t;

  localparam int NVEC = 13;
  localparam vec_t VEC [NVEC] = '{
    '{30*CPU,   1},   // mid raise window
    '{1*CPU,    1},   // lower edge of raise window
    '{60*CPU,   1},   // upper edge of raise window
    '{CPU-1,    0},   // under one microsecond
    '{61*CPU,   0},
    '{100*CPU,  0},
    '{139*CPU,  0},
    '{140*CPU, -1},   // lower edge of lower window
    '{200*CPU, -1},
    '{240*CPU, -1},   // upper edge of lower window
    '{241*CPU,  0},
    '{400*CPU,  0},
    '{559*CPU,  0}    // just short of shutdown
  };

  logic       clk = 1'b0;
  logic       rst;
  logic       ctrlPin;
  logic [5:0] dacCode;
  logic       enable;
  logic       softStart;
  logic       stepDone;

  int checks = 0;
  int failures = 0;
  int ssCnt = 0;
  int sdCnt = 0;
  bit finished = 1'b0;

  always #10 clk = ~clk;

  pulse_step_decoder #(.CLK_PER_US(CPU)) u_pulse_step_decoder (
    .clk      (clk),
    .rst      (rst),
    .ctrlPin  (ctrlPin),
    .dacCode  (dacCode),
    .enable   (enable),
    .softStart(softStart),
    .stepDone (stepDone)
  );

  always @(negedge clk) begin
    if (!rst) begin
      if (softStart) ssCnt++;
      if (stepDone)  sdCnt++;
    end
  end

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  task automatic lowPulse(input int lowCyc, input int gapCyc);
    ctrlPin = 1'b0;
    repeat (lowCyc) @(negedge clk);
    ctrlPin = 1'b1;
    repeat (gapCyc) @(negedge clk);
  endtask

  task automatic finish();
    if (!finished) begin
      finished = 1'b1;
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    checks++;
    failures++;
    $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
    finish();
  end

  initial begin
    int expCode;
    int sdBefore;
    rst = 1'b1;
    ctrlPin = 1'b0;
    repeat (5) @(negedge clk);
    rst = 1'b0;
    repeat (3) @(negedge clk);

    // R1 reset state
    chk(enable == 1'b0, "R1 enable", enable, 0);
    chk(dacCode == 6'd32, "R1 code", dacCode, 32);
    chk(ssCnt == 0 && sdCnt == 0, "R1 strobes", ssCnt + sdCnt, 0);

    // R2 first enable
    ctrlPin = 1'b1;
    repeat (6) @(negedge clk);
    chk(enable == 1'b1, "R2 enable", enable, 1);
    chk(dacCode == 6'd32, "R2 code", dacCode, 32);
    chk(ssCnt == 1, "R2 softstart", ssCnt, 1);

    // Vector table: R3 raise, R4 lower, R6 ignored widths
    expCode = 32;
    for (int i = 0; i < NVEC; i++) begin
      sdBefore = sdCnt;
      lowPulse(VEC[i].cyc, 8);
      expCode = expCode + VEC[i].delta;
      if (VEC[i].delta > 0) begin
        chk(dacCode == 6'(expCode), "R3 raise", dacCode, expCode);
        chk(sdCnt - sdBefore == 1, "R8 raise strobe", sdCnt - sdBefore, 1);
      end else if (VEC[i].delta < 0) begin
        chk(dacCode == 6'(expCode), "R4 lower", dacCode, expCode);
        chk(sdCnt - sdBefore == 1, "R8 lower strobe", sdCnt - sdBefore, 1);
      end else begin
        chk(dacCode == 6'(expCode), "R6 ignored code", dacCode, expCode);
        chk(sdCnt - sdBefore == 0, "R6 ignored strobe", sdCnt - sdBefore, 0);
        chk(enable == 1'b1, "R6 stays enabled", enable, 1);
      end
    end

    // R9 back-to-back raises with a 1 us gap, up to the top rail
    sdBefore = sdCnt;
    for (int k = 0; k < 31; k++) lowPulse(2*CPU, CPU);
    repeat (6) @(negedge clk);
    chk(dacCode == 6'd63, "R9 reach top", dacCode, 63);
    chk(sdCnt - sdBefore == 31, "R9 strobe count", sdCnt - sdBefore, 31);

    // R7 raise at top
    sdBefore = sdCnt;
    lowPulse(2*CPU, 8);
    chk(dacCode == 6'd63, "R7 top hold", dacCode, 63);
    chk(sdCnt - sdBefore == 0, "R7 top strobe", sdCnt - sdBefore, 0);

    // R5 shutdown while still low
    ctrlPin = 1'b0;
    repeat (560*CPU + 6) @(negedge clk);
    chk(enable == 1'b0, "R5 shutdown", enable, 0);
    chk(dacCode == 6'd63, "R5 code held", dacCode, 63);
    repeat (40) @(negedge clk);
    chk(dacCode == 6'd63, "R5 code still held", dacCode, 63);

    // R2 re-enable re-centres
    ctrlPin = 1'b1;
    repeat (6) @(negedge clk);
    chk(enable == 1'b1, "R2 re-enable", enable, 1);
    chk(dacCode == 6'd32, "R2 re-centre", dacCode, 32);
    chk(ssCnt == 2, "R2 second softstart", ssCnt, 2);

    // R4 lowers down to the bottom rail
    sdBefore = sdCnt;
    for (int k = 0; k < 32; k++) lowPulse(150*CPU, CPU);
    repeat (6) @(negedge clk);
    chk(dacCode == 6'd0, "R4 reach bottom", dacCode, 0);
    chk(sdCnt - sdBefore == 32, "R8 bottom strobe count", sdCnt - sdBefore, 32);

    // R7 lower at bottom
    sdBefore = sdCnt;
    lowPulse(150*CPU, 8);
    chk(dacCode == 6'd0, "R7 bottom hold", dacCode, 0);
    chk(sdCnt - sdBefore == 0, "R7 bottom strobe", sdCnt - sdBefore, 0);
    chk(enable == 1'b1, "R7 still enabled", enable, 1);

    finish();
  end

endmodule